// File: doc/BRIEF.md
# Swept-Frequency Sine Excitation Generator

This block produces a digital sine wave whose frequency moves through a programmed list of equally spaced points. Software loads a 24-bit start code, a 24-bit step code, a 9-bit number of steps and a 16-bit settling count through byte-wide register writes. It then drives the sweep with three commands: begin at the start frequency, advance to the next point, or hold the current point and measure it again.

A 27-bit phase accumulator advances once every fourth clock by the current frequency code. The output frequency is therefore code × (f_clk / 4) / 2^27. The top ten accumulator bits select a sample from a quarter-wave table that is mirrored into all four quadrants. The result is a 10-bit two's-complement code for a DAC. After each command that changes or repeats a point, the block counts whole output periods, which it detects as accumulator overflows. It raises a settled flag once the programmed number of periods has passed, so the settling delay in time is longer at low frequencies and shorter at high ones.

Top module: `sweep_exciter`

## Requirements
- R1: While reset is high and on the first cycle after it, `sample`, `freq_code`, `settled` and `sweep_done` are all zero.
- R2: Register writes (`wr_en` high) place `wr_data` at byte address `wr_addr`: 0, 1, 2 hold the start code bits 23:16, 15:8, 7:0; 3, 4, 5 hold the step code the same way; 6 bit 0 and 7 hold step-count bits 8 and 7:0; 8 and 9 hold settling-count bits 15:8 and 7:0. Other addresses change nothing. A begin command copies the start code to `freq_code` on the next cycle.
- R3: The begin command clears the phase accumulator and its divide-by-four prescaler. From then on, the accumulator adds `freq_code` modulo 2^27 on every fourth clock, the first time on the fourth clock after the command.
- R4: `sample` is registered from the accumulator value one clock earlier. With p = accumulator bits 26:17, it is within 2 LSB of round(511·sin(2π(p+0.5)/1024)) in two's complement.
- R5: Commands are coded on `cmd` as 0 none, 1 begin, 2 advance, 3 repeat. An advance while fewer than the programmed number of steps have been taken adds the step code to `freq_code` modulo 2^24 and restarts settling.
- R6: An advance after the programmed number of steps leaves `freq_code` and settling unchanged and sets `sweep_done`. `sweep_done` then stays high until the next begin command. A step count of zero makes the first advance complete the sweep.
- R7: A repeat restarts settling without changing `freq_code` or the phase, so `settled` is low on the next cycle unless the settling count is zero.
- R8: `settled` is high when the number of accumulator overflows counted since the last begin, advance or repeat equals the settling count latched by that command. An overflow on the command's own cycle is not counted. A count of zero gives `settled` on the cycle after the command.
- R9: Advance and repeat commands issued before the first begin command have no effect on any output.
- R10: Writing the start, step or settling registers does not change `freq_code` or the settling target of the current point. The new values take effect at the next command that loads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Register byte value |
| cmd | input | 2 | Sweep command: 0 none, 1 begin, 2 advance, 3 repeat |
| sample | output | 10 | Two's-complement sine sample for the DAC |
| freq_code | output | 24 | Frequency code of the current sweep point |
| settled | output | 1 | Settling periods have elapsed at the current point |
| sweep_done | output | 1 | An advance was requested past the last point |

## Verification
A command presented before a clock edge affects `freq_code`, `sweep_done` and `settled` on the following cycle. The sample output lags the accumulator by one register, so it reflects the phase of the cycle before. Overflows only happen on every fourth clock after a begin, so `settled` can rise only on those edges plus one. The bench keeps a cycle-level reference of the prescaler, accumulator, step and settling counters, updated at each rising edge from the stimulus and register map alone. It compares every output on the falling edge of the same cycle, so each result is sampled exactly in the cycle it becomes due. One slow sweep point walks the phase through all 1024 table addresses.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    localparam int FREQ_W   = 24;
    localparam int CNT_W    = 9;
    localparam int SETTLE_W = 16;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_BEGIN  = 2'd1,
        OP_ADV    = 2'd2,
        OP_REPEAT = 2'd3
    } sweep_op_e;

    typedef struct packed {
        logic [FREQ_W-1:0]   start_code;
        logic [FREQ_W-1:0]   step_code;
        logic [CNT_W-1:0]    step_total;
        logic [SETTLE_W-1:0] settle_periods;
    } sweep_cfg_t;

    // Rational sine approximation for the centre of quarter-wave entry k.
    // Angle = pi*(2k+1)/(4Q); t = angle/pi; sin ~ 16t(1-t)/(5-4t(1-t)).
    function automatic int quarter_sine(input int k, input int qbits, input int amp);
        longint b;
        longint a;
        longint prod;
        longint den;
        longint num;
        b    = longint'(4) << qbits;
        a    = 2 * longint'(k) + 1;
        prod = a * (b - a);
        den  = 5 * b * b - 4 * prod;
        num  = longint'(amp) * 16 * prod;
        return int'((num + den / 2) / den);
    endfunction

endpackage

// File: rtl/sweep_regs.sv
module sweep_regs
    import sweep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output sweep_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                4'd0: cfg.start_code[23:16]          <= wr_data;
                4'd1: cfg.start_code[15:8]           <= wr_data;
                4'd2: cfg.start_code[7:0]            <= wr_data;
                4'd3: cfg.step_code[23:16]           <= wr_data;
                4'd4: cfg.step_code[15:8]            <= wr_data;
                4'd5: cfg.step_code[7:0]             <= wr_data;
                4'd6: cfg.step_total[CNT_W-1:8]      <= wr_data[CNT_W-9:0];
                4'd7: cfg.step_total[7:0]            <= wr_data;
                4'd8: cfg.settle_periods[15:8]       <= wr_data;
                4'd9: cfg.settle_periods[7:0]        <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import sweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sweep_op_e         op,
    input  sweep_cfg_t        cfg,
    input  logic              wrap,
    output logic [FREQ_W-1:0] fword,
    output logic              phase_clear,
    output logic              settled,
    output logic              done
);

    logic                running;
    logic [CNT_W-1:0]    steps_taken;
    logic [SETTLE_W-1:0] period_cnt;
    logic [SETTLE_W-1:0] period_tgt;
    logic                do_begin;
    logic                do_adv;
    logic                adv_blocked;
    logic                restart;

    always_comb begin
        do_begin    = (op == OP_BEGIN);
        do_adv      = running && (op == OP_ADV) && (steps_taken < cfg.step_total);
        adv_blocked = running && (op == OP_ADV) && (steps_taken >= cfg.step_total);
        restart     = do_begin || do_adv || (running && op == OP_REPEAT);
    end

    assign phase_clear = do_begin;
    assign settled     = running && (period_cnt == period_tgt);

    always_ff @(posedge clk) begin
        if (rst) begin
            running     <= 1'b0;
            fword       <= '0;
            steps_taken <= '0;
            done        <= 1'b0;
        end else if (do_begin) begin
            running     <= 1'b1;
            fword       <= cfg.start_code;
            steps_taken <= '0;
            done        <= 1'b0;
        end else if (do_adv) begin
            fword       <= fword + cfg.step_code;
            steps_taken <= steps_taken + 1'b1;
        end else if (adv_blocked) begin
            done        <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_cnt <= '0;
            period_tgt <= '0;
        end else if (restart) begin
            period_cnt <= '0;
            period_tgt <= cfg.settle_periods;
        end else if (wrap && period_cnt != period_tgt) begin
            period_cnt <= period_cnt + 1'b1;
        end
    end

    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(op) == OP_NONE || $past(op) == OP_REPEAT) && !$past(rst) |-> $stable(fword)); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done && op != OP_BEGIN |=> done); // R6
    AST_REPEAT_RESTART: assert property (@(posedge clk) disable iff (rst)
        running && op == OP_REPEAT && cfg.settle_periods != '0 |=> !settled); // R7
    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        settled && op == OP_NONE |=> settled); // R8

endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int ACC_W  = 27,
    parameter int FW     = 24,
    parameter int DIV_W  = 2,
    parameter int OUT_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [FW-1:0]    fword,
    output logic [OUT_W-1:0] phase,
    output logic             wrap
);

    localparam int PAD_W = ACC_W + 1 - FW;

    logic [DIV_W-1:0] pre;
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;
    logic             tick;

    assign tick  = &pre;
    assign sum   = {1'b0, acc} + {{PAD_W{1'b0}}, fword};
    assign wrap  = tick && !clear && sum[ACC_W];
    assign phase = acc[ACC_W-1 -: OUT_W];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre <= '0;
            acc <= '0;
        end else begin
            pre <= pre + 1'b1;
            if (tick) begin
                acc <= sum[ACC_W-1:0];
            end
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) && !$past(clear) |-> $stable(acc)); // R3

endmodule

// File: rtl/sine_rom.sv
module sine_rom
    import sweep_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] phase,
    output logic [DW-1:0] sample
);

    localparam int QB    = AW - 2;
    localparam int QN    = 1 << QB;
    localparam int MAG_W = DW - 1;
    localparam int AMP   = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] quarter [QN];

    for (genvar i = 0; i < QN; i++) begin : g_rom
        assign quarter[i] = MAG_W'(quarter_sine(i, QB, AMP));
    end

    logic [QB-1:0]    idx;
    logic [MAG_W-1:0] mag;
    logic [DW-1:0]    pos;

    assign idx = phase[AW-2] ? ~phase[QB-1:0] : phase[QB-1:0];
    assign mag = quarter[idx];
    assign pos = {1'b0, mag};

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= '0;
        end else begin
            sample <= phase[AW-1] ? (~pos + 1'b1) : pos;
        end
    end

    AST_SAMPLE_SIGN: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> sample[DW-1] == $past(phase[AW-1])); // R4

endmodule

// File: rtl/sweep_exciter.sv
module sweep_exciter
    import sweep_pkg::*;
#(
    parameter int ACC_W  = 27,
    parameter int DIV_W  = 2,
    parameter int SAMP_W = 10,
    parameter int LUT_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        cmd,
    output logic [SAMP_W-1:0] sample,
    output logic [FREQ_W-1:0] freq_code,
    output logic              settled,
    output logic              sweep_done
);

    sweep_cfg_t          cfg;
    sweep_op_e           op;
    logic                clear;
    logic                wrap;
    logic [LUT_AW-1:0]   phase;

    assign op = sweep_op_e'(cmd);

    sweep_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    sweep_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .cfg         (cfg),
        .wrap        (wrap),
        .fword       (freq_code),
        .phase_clear (clear),
        .settled     (settled),
        .done        (sweep_done)
    );

    phase_accum #(
        .ACC_W (ACC_W),
        .FW    (FREQ_W),
        .DIV_W (DIV_W),
        .OUT_W (LUT_AW)
    ) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .fword (freq_code),
        .phase (phase),
        .wrap  (wrap)
    );

    sine_rom #(
        .AW (LUT_AW),
        .DW (SAMP_W)
    ) u_rom (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .sample (sample)
    );

endmodule

// File: tb/sim_sweep_exciter.sv
module sim_sweep_exciter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  cmd = 2'd0;
    logic [9:0]  sample;
    logic [23:0] freq_code;
    logic        settled;
    logic        sweep_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sweep_exciter u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmd        (cmd),
        .sample     (sample),
        .freq_code  (freq_code),
        .settled    (settled),
        .sweep_done (sweep_done)
    );

    // Reference model, built from the requirement text
    logic [1:0]  m_pre;
    logic [26:0] m_acc;
    logic        m_run;
    logic [23:0] m_fw;
    logic [8:0]  m_steps;
    logic [15:0] m_scnt, m_stgt;
    logic        m_done;
    logic [9:0]  m_sp;
    logic        m_sp_valid;
    logic [23:0] m_start, m_inc;
    logic [8:0]  m_total;
    logic [15:0] m_set;
    logic [27:0] m_sum;
    logic        m_wrap, m_restart;

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_acc = 0; m_run = 0; m_fw = 0; m_steps = 0;
            m_scnt = 0; m_stgt = 0; m_done = 0; m_sp = 0; m_sp_valid = 0;
            m_start = 0; m_inc = 0; m_total = 0; m_set = 0;
        end else begin
            m_sp = m_acc[26:17];
            m_sp_valid = 1;
            m_wrap = 0;
            m_restart = 0;
            if (cmd == 2'd1) begin
                m_pre = 0; m_acc = 0; m_run = 1; m_fw = m_start; m_steps = 0;
                m_done = 0; m_restart = 1;
            end else begin
                if (m_pre == 2'd3) begin
                    m_sum = {1'b0, m_acc} + {4'b0, m_fw};
                    m_wrap = m_sum[27];
                    m_acc = m_sum[26:0];
                end
                m_pre = m_pre + 2'd1;
                if (cmd == 2'd2 && m_run) begin
                    if (m_steps < m_total) begin
                        m_fw = m_fw + m_inc; m_steps = m_steps + 1; m_restart = 1;
                    end else begin
                        m_done = 1;
                    end
                end else if (cmd == 2'd3 && m_run) begin
                    m_restart = 1;
                end
            end
            if (m_restart) begin
                m_scnt = 0; m_stgt = m_set;
            end else if (m_wrap && m_scnt != m_stgt) begin
                m_scnt = m_scnt + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_start[23:16] = wr_data;
                    4'd1: m_start[15:8]  = wr_data;
                    4'd2: m_start[7:0]   = wr_data;
                    4'd3: m_inc[23:16]   = wr_data;
                    4'd4: m_inc[15:8]    = wr_data;
                    4'd5: m_inc[7:0]     = wr_data;
                    4'd6: m_total[8]     = wr_data[0];
                    4'd7: m_total[7:0]   = wr_data;
                    4'd8: m_set[15:8]    = wr_data;
                    4'd9: m_set[7:0]     = wr_data;
                    default: ;
                endcase
            end
        end
    end

    function automatic int ref_sample(input int p);
        real v;
        v = 511.0 * $sin(6.283185307179586 * (real'(p) + 0.5) / 1024.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int es, as;
            es = m_sp_valid ? ref_sample(int'(m_sp)) : 0;
            as = int'($signed(sample));
            chk((as - es <= 2) && (es - as <= 2), "R3 R4 sample", as, es);
            chk(freq_code == m_fw, "R5 freq_code", int'(freq_code), int'(m_fw));
            chk(settled == (m_run && m_scnt == m_stgt), "R8 settled",
                int'(settled), int'(m_run && m_scnt == m_stgt));
            chk(sweep_done == m_done, "R6 sweep_done", int'(sweep_done), int'(m_done));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic issue(input int op);
        @(negedge clk);
        cmd = 2'(op);
        @(negedge clk);
        cmd = 2'd0;
    endtask

    task automatic load(input int s, input int inc, input int tot, input int st);
        wr(0, s >> 16); wr(1, s >> 8); wr(2, s);
        wr(3, inc >> 16); wr(4, inc >> 8); wr(5, inc);
        wr(6, tot >> 8); wr(7, tot);
        wr(8, st >> 8); wr(9, st);
    endtask

    task automatic wait_settled(input int lim);
        for (int i = 0; i < lim && !settled; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sample == 0 && freq_code == 0 && !settled && !sweep_done, "R1 in reset", int'(sample), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(freq_code == 0 && !settled && !sweep_done, "R1 after reset", int'(freq_code), 0);

        // R9: advance and repeat before any begin
        load(24'h200000, 24'h080000, 3, 2);
        issue(2);
        chk(freq_code == 0 && !settled, "R9 advance before begin", int'(freq_code), 0);
        issue(3);
        chk(freq_code == 0 && !settled, "R9 repeat before begin", int'(freq_code), 0);

        // R2: begin loads start code
        issue(1);
        chk(freq_code == 24'h200000, "R2 start load", int'(freq_code), 24'h200000);
        chk(!settled, "R8 not settled after begin", int'(settled), 0);
        wait_settled(2000);
        chk(settled, "R8 settles at start", int'(settled), 1);

        // R5: three advances through the sweep
        for (int k = 1; k <= 3; k++) begin
            issue(2);
            chk(freq_code == 24'(24'h200000 + k * 24'h080000), "R5 advance",
                int'(freq_code), 24'h200000 + k * 24'h080000);
            chk(!settled, "R5 settle restart", int'(settled), 0);
            wait_settled(2000);
            chk(settled, "R8 settles after advance", int'(settled), 1);
        end

        // R6: advance past the last point
        issue(2);
        chk(freq_code == 24'h380000 && sweep_done && settled, "R6 final advance ignored",
            int'(freq_code), 24'h380000);
        repeat (20) @(negedge clk);
        chk(sweep_done, "R6 done holds", int'(sweep_done), 1);

        // R7: repeat restarts settling only
        issue(3);
        chk(!settled && freq_code == 24'h380000, "R7 repeat", int'(settled), 0);
        wait_settled(2000);
        chk(settled, "R7 resettles", int'(settled), 1);

        // R10: writes mid-point do not disturb it; zero settle takes effect at repeat
        wr(2, 8'h55);
        wr(8, 0); wr(9, 0);
        chk(freq_code == 24'h380000 && settled, "R10 writes latched", int'(freq_code), 24'h380000);
        issue(3);
        chk(settled, "R8 zero settle count", int'(settled), 1);

        // R6: zero-step sweep completes on first advance; begin clears done
        load(24'h0C0000, 24'h010000, 0, 1);
        issue(1);
        chk(!sweep_done && freq_code == 24'h0C0000, "R6 begin clears done", int'(sweep_done), 0);
        issue(2);
        chk(sweep_done && freq_code == 24'h0C0000, "R6 zero steps", int'(sweep_done), 1);

        // R3 R4: slow point walking all 1024 phase addresses
        load(24'h010000, 24'h000100, 1, 1);
        issue(1);
        wait_settled(12000);
        chk(settled, "R3 slow point full period", int'(settled), 1);
        issue(2);
        chk(freq_code == 24'h010100, "R5 small increment", int'(freq_code), 24'h010100);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule